// File: doc/BRIEF.md
# HI/LO multiply-accumulate unit

This block multiplies two 32-bit operands and places the 64-bit outcome in a pair of architectural result registers, HI (upper word) and LO (lower word). Beyond a plain product, it can add the product to the existing HI:LO value or take it away from that value. Every operation comes in a signed and an unsigned form. A caller issues an operation with a one-cycle start strobe and an operation code. The unit then runs its multiplier for a fixed number of cycles and reports the finish with a one-cycle done pulse.

Software may also load HI or LO directly through a write port. Such a write changes only the half it selects, and the unit refuses it while an operation is in flight. The multiplier works digit-serially, taking `DIGIT_W` bits of the second operand per cycle. The HI:LO value that feeds an accumulate is read in the final cycle of the operation, not when the operation starts.

Top module: `hilo_mac`

## Requirements
- R1: While reset is held and in the first cycle after it, HI and LO read zero and busy and done are low.
- R2: Operation code 0 (signed multiply) sign-extends both operands to 64 bits and writes the low 64 bits of the product to HI:LO, with HI holding bits 63:32 and LO holding bits 31:0.
- R3: Operation code 1 (unsigned multiply) zero-extends both operands and writes the 64-bit product to HI:LO.
- R4: Operation codes 2 (signed) and 3 (unsigned) add the product, extended as in R2 or R3, to the HI:LO value and write the sum back modulo 2^64.
- R5: Operation codes 4 (signed) and 5 (unsigned) subtract the product from the HI:LO value and write the difference back modulo 2^64.
- R6: A start with operation code 6 or 7 is ignored: busy stays low, no done pulse occurs and HI and LO do not change.
- R7: After a start is accepted, busy is high from the next cycle until the result is written. Done is a one-cycle pulse that appears DATA_W/DIGIT_W+2 cycles after the accepting edge. In that cycle busy is low and HI and LO already hold the result.
- R8: A start that arrives while busy is high is ignored. It produces no second result and no second done pulse.
- R9: When busy is low, a direct write with the HI enable loads wrData into HI only, and a write with the LO enable loads wrData into LO only. Both enables may be set together.
- R10: While busy is high, direct writes are rejected and HI and LO hold their values until the result is written.
- R11: A direct write in the same cycle as an accepted start takes effect, and an accumulate operation then uses the HI:LO value that includes that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe for an operation |
| op | input | 3 | Operation code (0 to 5 valid) |
| opA | input | DATA_W (32) | First operand |
| opB | input | DATA_W (32) | Second operand |
| hiWe | input | 1 | Direct write enable for HI |
| loWe | input | 1 | Direct write enable for LO |
| wrData | input | DATA_W (32) | Data for direct writes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | DATA_W (32) | Upper result word |
| lo | output | DATA_W (32) | Lower result word |

## Verification
Two functions can fall in the same cycle: a direct write to HI or LO and the start of an operation. The bench raises both strobes at the same clock edge while the unit is idle. For an accumulate, the expected sum is built on HI:LO with the write already applied. The bench also holds both write enables high through every busy cycle, including the final write-back cycle, and holds start high in the first and last busy cycles. It then checks that the result is exactly that of the first operation, with a single done pulse.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;

  typedef enum logic [2:0] {
    OP_MUL   = 3'd0,
    OP_MULU  = 3'd1,
    OP_MADD  = 3'd2,
    OP_MADDU = 3'd3,
    OP_MSUB  = 3'd4,
    OP_MSUBU = 3'd5
  } mac_op_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_ADD  = 2'd1,
    ACC_SUB  = 2'd2
  } acc_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture operands and operation
    logic step;    // one digit of the multiplier
    logic commit;  // write final value to HI:LO
  } dp_strobe_t;

  function automatic logic opValid(input logic [2:0] code);
    return code <= OP_MSUBU;
  endfunction

  // even codes are the signed forms
  function automatic logic opSigned(input logic [2:0] code);
    return ~code[0];
  endfunction

  function automatic acc_mode_e opAcc(input logic [2:0] code);
    acc_mode_e m;
    case (code)
      OP_MADD, OP_MADDU: m = ACC_ADD;
      OP_MSUB, OP_MSUBU: m = ACC_SUB;
      default:           m = ACC_NONE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/hilo_mac_ctrl.sv
module hilo_mac_ctrl
  import hilo_mac_pkg::*;
#(
  parameter int STEPS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] op,
  output logic       busy,
  output logic       done,
  output dp_strobe_t strobe
);

  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FINISH = 2'd2
  } ctrl_state_e;

  ctrl_state_e state;
  logic [CNT_W-1:0] stepCnt;
  logic doneR;

  always_comb begin
    strobe.load   = (state == ST_IDLE) && start && opValid(op);
    strobe.step   = (state == ST_RUN);
    strobe.commit = (state == ST_FINISH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneR   <= 1'b0;
    end else begin
      doneR <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (strobe.load) begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end
        end
        ST_RUN: begin
          if (stepCnt == LAST_STEP) begin
            state <= ST_FINISH;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        ST_FINISH: begin
          state <= ST_IDLE;
          doneR <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneR;

endmodule

// File: rtl/hilo_mac_dp.sv
module hilo_mac_dp
  import hilo_mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic              busy,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              hiWe,
  input  logic              loWe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] hi,
  output logic [DATA_W-1:0] lo
);

  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] mcand;
  logic [DATA_W-1:0] mplier;
  logic [PROD_W-1:0] partial;
  logic              negRes;
  acc_mode_e         accMode;
  logic [DATA_W-1:0] hiR;
  logic [DATA_W-1:0] loR;

  logic [DATA_W-1:0] magA;
  logic [DATA_W-1:0] magB;
  logic              sgnOp;
  logic [PROD_W-1:0] terms [DIGIT_W];
  logic [PROD_W-1:0] stepAdd;
  logic [PROD_W-1:0] product;
  logic [PROD_W-1:0] hiloNow;
  logic [PROD_W-1:0] finalVal;

  // magnitudes of the operands for the unsigned core
  always_comb begin
    sgnOp = opSigned(op);
    magA  = (sgnOp && opA[DATA_W-1]) ? -opA : opA;
    magB  = (sgnOp && opB[DATA_W-1]) ? -opB : opB;
  end

  // one shifted multiplicand per bit of the current digit
  for (genvar i = 0; i < DIGIT_W; i++) begin : g_term
    assign terms[i] = mplier[i] ? (mcand << i) : '0;
  end

  always_comb begin
    stepAdd = '0;
    for (int i = 0; i < DIGIT_W; i++) begin
      stepAdd = stepAdd + terms[i];
    end
  end

  always_comb begin
    product = negRes ? -partial : partial;
    hiloNow = {hiR, loR};
    case (accMode)
      ACC_ADD: finalVal = hiloNow + product;
      ACC_SUB: finalVal = hiloNow - product;
      default: finalVal = product;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand   <= '0;
      mplier  <= '0;
      partial <= '0;
      negRes  <= 1'b0;
      accMode <= ACC_NONE;
    end else if (strobe.load) begin
      mcand   <= {{DATA_W{1'b0}}, magA};
      mplier  <= magB;
      partial <= '0;
      negRes  <= sgnOp && (opA[DATA_W-1] ^ opB[DATA_W-1]);
      accMode <= opAcc(op);
    end else if (strobe.step) begin
      partial <= partial + stepAdd;
      mcand   <= mcand << DIGIT_W;
      mplier  <= mplier >> DIGIT_W;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiR <= '0;
      loR <= '0;
    end else if (strobe.commit) begin
      {hiR, loR} <= finalVal;
    end else if (!busy) begin
      if (hiWe) hiR <= wrData;
      if (loWe) loR <= wrData;
    end
  end

  assign hi = hiR;
  assign lo = loR;

endmodule

// File: rtl/hilo_mac.sv
module hilo_mac
  import hilo_mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              hiWe,
  input  logic              loWe,
  input  logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] hi,
  output logic [DATA_W-1:0] lo
);

  localparam int NUM_STEPS = DATA_W / DIGIT_W;

  dp_strobe_t strobe;

  hilo_mac_ctrl #(
    .STEPS(NUM_STEPS)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .op    (op),
    .busy  (busy),
    .done  (done),
    .strobe(strobe)
  );

  hilo_mac_dp #(
    .DATA_W (DATA_W),
    .DIGIT_W(DIGIT_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .busy  (busy),
    .op    (op),
    .opA   (opA),
    .opB   (opB),
    .hiWe  (hiWe),
    .loWe  (loWe),
    .wrData(wrData),
    .hi    (hi),
    .lo    (lo)
  );

endmodule

// File: rtl/hilo_mac_checker.sv
module hilo_mac_checker #(
  parameter int DATA_W = 32,
  parameter int LAT    = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [2:0]        op,
  input logic              hiWe,
  input logic [DATA_W-1:0] wrData,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] hi,
  input logic [DATA_W-1:0] lo
);

  int unsigned latCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latCnt <= 0;
    end else if (!busy && start && (op <= 3'd5)) begin
      latCnt <= 1;
    end else if (busy) begin
      latCnt <= latCnt + 1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (hi == '0 && lo == '0 && !busy && !done));

  assert_bad_op_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && op > 3'd5) |=> !busy);

  assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (latCnt == LAT));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_direct_hi_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && hiWe) |=> (hi == $past(wrData)));

  assert_hold_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || ($stable(hi) && $stable(lo))));

endmodule

bind hilo_mac hilo_mac_checker #(
  .DATA_W(DATA_W),
  .LAT   (NUM_STEPS + 2)
) u_hilo_mac_checker (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .op    (op),
  .hiWe  (hiWe),
  .wrData(wrData),
  .busy  (busy),
  .done  (done),
  .hi    (hi),
  .lo    (lo)
);

// File: tb/hilo_mac_bench.sv
`timescale 1ns/1ps
module hilo_mac_bench;

  localparam int LAT = 32 / 4 + 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        hiWe = 1'b0;
  logic        loWe = 1'b0;
  logic [31:0] wrData = '0;
  logic        busy;
  logic        done;
  logic [31:0] hi;
  logic [31:0] lo;

  int total = 0;
  int bad = 0;
  logic [63:0] model = '0;

  always #4 clk = ~clk;

  hilo_mac u_hilo_mac (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .opA(opA), .opB(opB),
    .hiWe(hiWe), .loWe(loWe), .wrData(wrData),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] prodOf(input logic [2:0] c,
                                         input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ea;
    logic [63:0] eb;
    ea = c[0] ? {32'b0, a} : {{32{a[31]}}, a};
    eb = c[0] ? {32'b0, b} : {{32{b[31]}}, b};
    return ea * eb;
  endfunction

  function automatic logic [63:0] expectOp(input logic [2:0] c, input logic [31:0] a,
                                           input logic [31:0] b, input logic [63:0] base);
    logic [63:0] p;
    p = prodOf(c, a, b);
    if (c == 3'd2 || c == 3'd3) return base + p;
    if (c == 3'd4 || c == 3'd5) return base - p;
    return p;
  endfunction

  // issue one operation; optional coincident write, writes while busy, stray starts
  task automatic runOp(input string req, input logic [2:0] c, input logic [31:0] a,
                       input logic [31:0] b, input bit wHi, input bit wLo,
                       input logic [31:0] wd, input bit wrBusy, input bit stray);
    logic [63:0] base;
    logic [63:0] exp;
    base = model;
    if (wHi) base[63:32] = wd;
    if (wLo) base[31:0] = wd;
    exp = expectOp(c, a, b, base);
    start = 1'b1; op = c; opA = a; opB = b;
    hiWe = wHi; loWe = wLo; wrData = wd;
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      if (k == 1) begin
        check("R7", "busy after start", {63'b0, busy}, 64'd1);
        start = stray; op = 3'd1; opA = 32'hFFFF_FFFF; opB = 32'h0000_0003;
        hiWe = wrBusy; loWe = wrBusy; wrData = 32'hDEAD_BEEF;
      end else if (k == 2) begin
        start = 1'b0;
      end else if (k == LAT - 1) begin
        check("R7", "no early done", {63'b0, done}, 64'd0);
        start = stray;
      end else if (k == LAT) begin
        start = 1'b0; hiWe = 1'b0; loWe = 1'b0;
      end
    end
    check("R7", "done pulse", {63'b0, done}, 64'd1);
    check("R7", "idle at done", {63'b0, busy}, 64'd0);
    check(req, "HI:LO result", {hi, lo}, exp);
    model = exp;
    @(negedge clk);
    check("R7", "done one cycle", {63'b0, done}, 64'd0);
    if (stray || wrBusy) begin
      repeat (LAT) @(negedge clk);
      check(req, "no second result", {hi, lo}, exp);
    end
  endtask

  task automatic writeHalf(input bit wHi, input bit wLo, input logic [31:0] d);
    hiWe = wHi; loWe = wLo; wrData = d;
    @(negedge clk);
    hiWe = 1'b0; loWe = 1'b0;
    if (wHi) model[63:32] = d;
    if (wLo) model[31:0] = d;
    check("R9", "direct write", {hi, lo}, model);
  endtask

  task automatic badOp(input logic [2:0] c);
    bit sawDone;
    bit sawBusy;
    sawDone = 1'b0;
    sawBusy = 1'b0;
    start = 1'b1; op = c; opA = 32'h0000_0005; opB = 32'h0000_0007;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < LAT + 2; k++) begin
      if (done) sawDone = 1'b1;
      if (busy) sawBusy = 1'b1;
      @(negedge clk);
    end
    check("R6", "busy on bad code", {63'b0, sawBusy}, 64'd0);
    check("R6", "done on bad code", {63'b0, sawDone}, 64'd0);
    check("R6", "HI:LO unchanged", {hi, lo}, model);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1", "HI:LO in reset", {hi, lo}, 64'd0);
    check("R1", "busy/done in reset", {62'b0, busy, done}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "HI:LO after reset", {hi, lo}, 64'd0);
  endtask

  task automatic testSignedMul();
    runOp("R2", 3'd0, 32'hFFFF_FFFD, 32'd7, 0, 0, '0, 0, 0);
    runOp("R2", 3'd0, 32'h8000_0000, 32'h8000_0000, 0, 0, '0, 0, 0);
    runOp("R2", 3'd0, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, '0, 0, 0);
  endtask

  task automatic testUnsignedMul();
    runOp("R3", 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, '0, 0, 0);
    runOp("R3", 3'd1, 32'h0000_0000, 32'h0001_2345, 0, 0, '0, 0, 0);
  endtask

  task automatic testMadd();
    writeHalf(1, 1, 32'hFFFF_FFFF);
    runOp("R4", 3'd2, 32'd1, 32'd1, 0, 0, '0, 0, 0);
    runOp("R4", 3'd3, 32'hFFFF_FFFF, 32'd2, 0, 0, '0, 0, 0);
    runOp("R4", 3'd2, 32'hFFFF_FFFF, 32'd5, 0, 0, '0, 0, 0);
  endtask

  task automatic testMsub();
    writeHalf(1, 1, 32'h0000_0000);
    runOp("R5", 3'd4, 32'd1, 32'd1, 0, 0, '0, 0, 0);
    runOp("R5", 3'd5, 32'h8000_0001, 32'h0000_0010, 0, 0, '0, 0, 0);
    runOp("R5", 3'd4, 32'hFFFF_FFFE, 32'd3, 0, 0, '0, 0, 0);
  endtask

  task automatic testDirectWrite();
    writeHalf(1, 0, 32'h1234_5678);
    writeHalf(0, 1, 32'h9ABC_DEF0);
    writeHalf(1, 1, 32'h0F0F_0F0F);
  endtask

  task automatic testBadOps();
    badOp(3'd6);
    badOp(3'd7);
  endtask

  task automatic testStartWhileBusy();
    runOp("R8", 3'd0, 32'h0000_1234, 32'hFFFF_0001, 0, 0, '0, 0, 1);
  endtask

  task automatic testWriteWhileBusy();
    runOp("R10", 3'd3, 32'h0102_0304, 32'h0506_0708, 0, 0, '0, 1, 0);
  endtask

  task automatic testCoincident();
    runOp("R11", 3'd2, 32'hFFFF_FF00, 32'h0000_0100, 1, 1, 32'h5555_AAAA, 0, 0);
    runOp("R11", 3'd4, 32'h0000_0003, 32'h0000_0004, 1, 0, 32'h0000_0001, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R7 watchdog: actual hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testDirectWrite();
    testSignedMul();
    testUnsignedMul();
    testMadd();
    testMsub();
    testBadOps();
    testStartWhileBusy();
    testWriteWhileBusy();
    testCoincident();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule